// File: doc/BRIEF.md
# DMA Global Control and Interrupt Aggregator

This block is the shared register bank that sits beside the channel engines of a multi-channel DMA controller. It owns the controller-wide enable, two sticky summary flags that record whether any channel has halted or hit an address fault, a per-channel interrupt pending vector that is folded into a single interrupt line, a per-channel clock-enable vector, and a doorbell that asks selected channels to fetch their next descriptor.

Software reaches it through a 32-bit word-addressed write port and a combinational read port. Each channel engine reports three status levels (transfer terminated, halted, address error) and receives a clock-enable level and a one-cycle descriptor-fetch request. The channel count is a parameter from 1 to 32. Registers are selected by the byte offset bits [4:2], and bits [1:0] are ignored.

Top module: `dma_glb_ctl`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, `irq` is 0, and every `ch_fetch_req` and `ch_clk_en` bit is 0.
- R2: The control register at offset 0x00 stores written bits 0 (global enable), 27 and 31 and reads them back. Software cannot set bits 2 and 3. Every other control bit reads 0.
- R3: Control bit 2 is set on any edge where some channel's address-error input rises, and control bit 3 on any edge where some channel's halt input rises. Each bit stays set until a control write carries 0 in that bit. A write with 1 leaves the bit unchanged, and a rising input on the same edge wins over the clearing write.
- R4: Pending bit n at offset 0x04 is set on an edge where any of channel n's terminated, halt or address-error inputs is 1 and was 0 on the previous edge. An input that stays high does not set the bit again.
- R5: A write to offset 0x04 clears each pending bit written as 0 and leaves each bit written as 1 unchanged, so software cannot set a bit. A new event on the same edge wins over the clear.
- R6: `irq` is 1 exactly when the global enable is 1 and at least one pending bit is 1.
- R7: A write to offset 0x10 replaces the whole clock-enable vector, which reads back at 0x10 and drives `ch_clk_en`.
- R8: A write to offset 0x14 turns on the clock enables whose mask bits are 1. A write to offset 0x18 turns off the clock enables whose mask bits are 1. All other bits are unchanged, and both aliases read 0.
- R9: A write of a mask to offset 0x0C drives `ch_fetch_req[n]` high for exactly the one cycle after the write edge, for each n whose mask bit is 1 and whose clock enable is 1. Other channels get no request. Offset 0x08 reads the request vector and ignores writes.
- R10: Offset 0x1C is a plain read/write per-channel mask.
- R11: For every per-channel register, bits at and above the channel count read 0 and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_term | input | NUM_CH | Per-channel transfer-terminated status |
| ch_halt | input | NUM_CH | Per-channel halt status |
| ch_aerr | input | NUM_CH | Per-channel address-error status |
| ch_fetch_req | output | NUM_CH | One-cycle descriptor-fetch requests |
| ch_clk_en | output | NUM_CH | Per-channel clock enables |
| irq | output | 1 | Aggregated interrupt |

## Verification
The assertions assume at most one register write per cycle. They also assume the status inputs are synchronous levels that hold their value across each clock edge. The bench changes the inputs only on the falling edge, and it issues writes through a task that asserts the strobe for a single cycle. This means a doorbell can never share a cycle with a clock-enable update. The rising-edge check on pending bits ignores the first few cycles after reset, because the history it compares against does not exist yet.

// File: rtl/dgc_pkg.sv
// Shared constants and types for the DMA global control block.
// Assumes a 32-bit register port and word offsets taken from address bits [4:2].
package dgc_pkg;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 32;
    localparam int SEL_W      = 3;
    localparam int NUM_REGS   = 1 << SEL_W;

    // Word index of each register (byte offset >> 2).
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_PEND  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DBELL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_RING  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CKEN  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CKSET = 3'd5;
    localparam logic [SEL_W-1:0] SEL_CKCLR = 3'd6;
    localparam logic [SEL_W-1:0] SEL_PROG  = 3'd7;

    // Control register bit positions.
    localparam int CB_EN    = 0;
    localparam int CB_AERR  = 2;
    localparam int CB_HALT  = 3;
    localparam int CB_MODEA = 27;
    localparam int CB_MODEB = 31;

    typedef struct packed {
        logic mode_b;
        logic mode_a;
        logic halt;
        logic aerr;
        logic en;
    } glb_ctl_t;
endpackage

// File: rtl/dgc_event_latch.sv
// Per-channel rising-edge detection of the status inputs and the sticky pending vector.
// Assumes status inputs are synchronous to clk. A new event wins over a software clear.
module dgc_event_latch #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] src_term,
    input  logic [NUM_CH-1:0] src_halt,
    input  logic [NUM_CH-1:0] src_aerr,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_keep,
    output logic [NUM_CH-1:0] pend,
    output logic              any_halt_rise,
    output logic              any_aerr_rise
);
    logic [NUM_CH-1:0] halt_rise;
    logic [NUM_CH-1:0] aerr_rise;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic prev_t, prev_h, prev_a;
        logic rise_t;

        // Remember last sampled status levels for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_t <= 1'b0;
                prev_h <= 1'b0;
                prev_a <= 1'b0;
            end else begin
                prev_t <= src_term[i];
                prev_h <= src_halt[i];
                prev_a <= src_aerr[i];
            end
        end

        assign rise_t       = src_term[i] & ~prev_t;
        assign halt_rise[i] = src_halt[i] & ~prev_h;
        assign aerr_rise[i] = src_aerr[i] & ~prev_a;

        // Sticky pending bit: set by any rising status, cleared by write-0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (rise_t | halt_rise[i] | aerr_rise[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_we && !clr_keep[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

    assign any_halt_rise = |halt_rise;
    assign any_aerr_rise = |aerr_rise;
endmodule

// File: rtl/dgc_control.sv
// Global control register: enable, two stored mode bits and two sticky summary flags.
// Assumes at most one write per cycle. A hardware flag event wins over a clear.
module dgc_control
    import dgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              halt_evt,
    input  logic              aerr_evt,
    output glb_ctl_t          ctl,
    output logic [DATA_W-1:0] rd_word
);
    // Plain stored bits load on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.en     <= 1'b0;
            ctl.mode_a <= 1'b0;
            ctl.mode_b <= 1'b0;
        end else if (wr_en) begin
            ctl.en     <= wdata[CB_EN];
            ctl.mode_a <= wdata[CB_MODEA];
            ctl.mode_b <= wdata[CB_MODEB];
        end
    end

    // Summary address-error flag: set by hardware, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.aerr <= 1'b0;
        end else if (aerr_evt) begin
            ctl.aerr <= 1'b1;
        end else if (wr_en && !wdata[CB_AERR]) begin
            ctl.aerr <= 1'b0;
        end
    end

    // Summary halt flag: set by hardware, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.halt <= 1'b0;
        end else if (halt_evt) begin
            ctl.halt <= 1'b1;
        end else if (wr_en && !wdata[CB_HALT]) begin
            ctl.halt <= 1'b0;
        end
    end

    // Place the fields at their bit positions for read-back.
    always_comb begin
        rd_word           = '0;
        rd_word[CB_EN]    = ctl.en;
        rd_word[CB_AERR]  = ctl.aerr;
        rd_word[CB_HALT]  = ctl.halt;
        rd_word[CB_MODEA] = ctl.mode_a;
        rd_word[CB_MODEB] = ctl.mode_b;
    end
endmodule

// File: rtl/dgc_clock_enables.sv
// Per-channel clock-enable vector with a plain write port and set/clear aliases.
// Assumes the three write strobes are mutually exclusive.
module dgc_clock_enables #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_plain,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [NUM_CH-1:0] wmask,
    output logic [NUM_CH-1:0] ce
);
    // Update the enable vector according to the selected alias.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce <= '0;
        end else if (wr_plain) begin
            ce <= wmask;
        end else if (wr_set) begin
            ce <= ce | wmask;
        end else if (wr_clr) begin
            ce <= ce & ~wmask;
        end
    end
endmodule

// File: rtl/dgc_doorbell.sv
// Descriptor-fetch doorbell: a written mask becomes a one-cycle request per enabled channel.
// Assumes requests to channels whose clock is off must be dropped.
module dgc_doorbell #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring,
    input  logic [NUM_CH-1:0] wmask,
    input  logic [NUM_CH-1:0] ce,
    output logic [NUM_CH-1:0] req
);
    // Register the gated mask for a single cycle, then self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else if (ring) begin
            req <= wmask & ce;
        end else begin
            req <= '0;
        end
    end
endmodule

// File: rtl/dma_glb_ctl.sv
// Top of the DMA global control block: address decode, read mux, submodule wiring.
// Assumes 1 <= NUM_CH <= 32 and a single write per cycle.
module dma_glb_ctl
    import dgc_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ch_term,
    input  logic [NUM_CH-1:0] ch_halt,
    input  logic [NUM_CH-1:0] ch_aerr,
    output logic [NUM_CH-1:0] ch_fetch_req,
    output logic [NUM_CH-1:0] ch_clk_en,
    output logic              irq
);
    logic [SEL_W-1:0]    sel;
    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_CH-1:0]   wmask;
    logic [NUM_CH-1:0]   pend_vec;
    logic [NUM_CH-1:0]   prog_q;
    logic                halt_evt, aerr_evt;
    glb_ctl_t            ctl_q;
    logic [DATA_W-1:0]   ctl_word;
    logic                glb_en, glb_aerr, glb_halt;

    assign sel   = bus_addr[REG_AW-1:2];
    assign wmask = bus_wdata[NUM_CH-1:0];

    // One-hot write select from the word offset.
    always_comb begin
        wr_sel = '0;
        if (bus_wr_en) wr_sel[sel] = 1'b1;
    end

    dgc_control u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_sel[SEL_CTRL]),
        .wdata    (bus_wdata),
        .halt_evt (halt_evt),
        .aerr_evt (aerr_evt),
        .ctl      (ctl_q),
        .rd_word  (ctl_word)
    );

    dgc_event_latch #(.NUM_CH(NUM_CH)) u_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_term      (ch_term),
        .src_halt      (ch_halt),
        .src_aerr      (ch_aerr),
        .clr_we        (wr_sel[SEL_PEND]),
        .clr_keep      (wmask),
        .pend          (pend_vec),
        .any_halt_rise (halt_evt),
        .any_aerr_rise (aerr_evt)
    );

    dgc_clock_enables #(.NUM_CH(NUM_CH)) u_cke (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_plain (wr_sel[SEL_CKEN]),
        .wr_set   (wr_sel[SEL_CKSET]),
        .wr_clr   (wr_sel[SEL_CKCLR]),
        .wmask    (wmask),
        .ce       (ch_clk_en)
    );

    dgc_doorbell #(.NUM_CH(NUM_CH)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .ring  (wr_sel[SEL_RING]),
        .wmask (wmask),
        .ce    (ch_clk_en),
        .req   (ch_fetch_req)
    );

    // Plain per-channel mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= '0;
        end else if (wr_sel[SEL_PROG]) begin
            prog_q <= wmask;
        end
    end

    assign glb_en   = ctl_q.en;
    assign glb_aerr = ctl_q.aerr;
    assign glb_halt = ctl_q.halt;

    // Aggregated interrupt line.
    assign irq = glb_en & (|pend_vec);

    // Read multiplexer; per-channel values zero-extended to the bus width.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL:  bus_rdata = ctl_word;
            SEL_PEND:  bus_rdata[NUM_CH-1:0] = pend_vec;
            SEL_DBELL: bus_rdata[NUM_CH-1:0] = ch_fetch_req;
            SEL_CKEN:  bus_rdata[NUM_CH-1:0] = ch_clk_en;
            SEL_PROG:  bus_rdata[NUM_CH-1:0] = prog_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dgc_checker.sv
// Assertion checker for dma_glb_ctl, attached by bind below.
// Assumes one write per cycle and synchronous status inputs.
module dgc_checker #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [4:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CH-1:0] ch_term,
    input logic [NUM_CH-1:0] ch_halt,
    input logic [NUM_CH-1:0] ch_aerr,
    input logic [NUM_CH-1:0] ch_fetch_req,
    input logic [NUM_CH-1:0] ch_clk_en,
    input logic              irq,
    input logic [NUM_CH-1:0] pend,
    input logic              glb_en,
    input logic              glb_aerr
);
    logic [1:0] age;

    // Cycles since reset, saturating, to gate history-dependent checks.
    always_ff @(posedge clk) begin
        if (!rst_n) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r9_fetch_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_fetch_req & ~ch_clk_en) == '0);

    a_r9_fetch_after_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_fetch_req != '0) |-> ($past(bus_wr_en) && ($past(bus_addr[4:2]) == 3'd3)));

    a_r9_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_fetch_req != '0) && !(bus_wr_en && (bus_addr[4:2] == 3'd3))) |=> (ch_fetch_req == '0));

    a_r6_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq);

    a_r6_irq_on_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && (pend != '0)) |-> irq);

    a_r4_pend_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> ((pend & ~$past(pend)
            & ~(($past(ch_term) & ~$past(ch_term, 2))
              | ($past(ch_halt) & ~$past(ch_halt, 2))
              | ($past(ch_aerr) & ~$past(ch_aerr, 2)))) == '0));

    a_r3_aerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(glb_aerr) && !($past(bus_wr_en) && ($past(bus_addr[4:2]) == 3'd0)
            && !$past(bus_wdata[2]))) |-> glb_aerr);

    a_r8_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_wr_en) && ($past(bus_addr[4:2]) == 3'd6))
            |-> ((ch_clk_en & $past(bus_wdata[NUM_CH-1:0])) == '0));

    a_r8_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_wr_en) && ($past(bus_addr[4:2]) == 3'd5))
            |-> ((~ch_clk_en & $past(bus_wdata[NUM_CH-1:0])) == '0));
endmodule

bind dma_glb_ctl dgc_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .ch_term      (ch_term),
    .ch_halt      (ch_halt),
    .ch_aerr      (ch_aerr),
    .ch_fetch_req (ch_fetch_req),
    .ch_clk_en    (ch_clk_en),
    .irq          (irq),
    .pend         (pend_vec),
    .glb_en       (glb_en),
    .glb_aerr     (glb_aerr)
);

// File: tb/dma_glb_ctl_tb.sv
module dma_glb_ctl_tb;
    localparam int NCH = 6;
    localparam int LIM = 150000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr_en = 1'b0;
    logic [4:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] ch_term = '0, ch_halt = '0, ch_aerr = '0;
    logic [NCH-1:0] ch_fetch_req, ch_clk_en;
    logic           irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] rv;

    dma_glb_ctl #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_term(ch_term),
        .ch_halt(ch_halt), .ch_aerr(ch_aerr), .ch_fetch_req(ch_fetch_req),
        .ch_clk_en(ch_clk_en), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIM) begin
            bad = bad + 1;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write; returns at the falling edge after the write edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), rv);
            check("R1 reset read", rv, 32'h0);
        end
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 fetch/clk", {20'h0, ch_fetch_req, ch_clk_en}, 32'h0);

        // R2 control storage
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, rv);
        check("R2 ctrl all ones", rv, 32'h8800_0001);
        wr(5'h00, 32'h0800_0000);
        rd(5'h00, rv);
        check("R2 ctrl mode a", rv, 32'h0800_0000);
        wr(5'h00, 32'h0);

        // R7 R11 plain clock-enable sweep
        for (int v = 0; v < 64; v++) begin
            wr(5'h10, 32'hFFFF_FFC0 | 32'(v));
            rd(5'h10, rv);
            check("R7 R11 cken read", rv, 32'(v));
            check("R7 cken pins", 32'(ch_clk_en), 32'(v));
        end

        // R8 set/clear aliases, full base x mask sweep
        for (int b = 0; b < 64; b++) begin
            for (int m = 0; m < 64; m++) begin
                wr(5'h10, 32'(b));
                wr(5'h14, 32'(m));
                check("R8 set alias", 32'(ch_clk_en), 32'(b | m));
                wr(5'h10, 32'(b));
                wr(5'h18, 32'(m));
                check("R8 clear alias", 32'(ch_clk_en), 32'(b & ~m & 63));
            end
        end
        wr(5'h10, 32'h3F);
        rd(5'h14, rv); check("R8 set alias reads 0", rv, 32'h0);
        rd(5'h18, rv); check("R8 clear alias reads 0", rv, 32'h0);

        // R9 doorbell gated by clock enable, every combination
        for (int c = 0; c < 64; c++) begin
            wr(5'h10, 32'(c));
            for (int m = 0; m < 64; m++) begin
                wr(5'h0C, 32'(m));
                check("R9 fetch pulse", 32'(ch_fetch_req), 32'(m & c));
                rd(5'h08, rv);
                check("R9 doorbell read", rv, 32'(m & c));
                @(negedge clk);
                check("R9 fetch self-clear", 32'(ch_fetch_req), 32'h0);
            end
        end
        wr(5'h10, 32'h3F);
        wr(5'h08, 32'h3F);
        check("R9 write to 0x08 ignored", 32'(ch_fetch_req), 32'h0);

        // R4 R5 R6 R3 per-channel, per-source events
        wr(5'h00, 32'h1);
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                if (s == 0) ch_term[c] = 1'b1;
                if (s == 1) ch_halt[c] = 1'b1;
                if (s == 2) ch_aerr[c] = 1'b1;
                @(negedge clk);
                rd(5'h04, rv);
                check("R4 pending set", rv, 32'(1 << c));
                check("R6 irq high", {31'h0, irq}, 32'h1);
                rd(5'h00, rv);
                check("R3 summary flags", rv,
                      32'h1 | (s == 1 ? 32'h8 : 32'h0) | (s == 2 ? 32'h4 : 32'h0));
                wr(5'h04, 32'h0);
                repeat (2) @(negedge clk);
                rd(5'h04, rv);
                check("R4 R5 held level no re-set", rv, 32'h0);
                check("R6 irq low", {31'h0, irq}, 32'h0);
                wr(5'h00, 32'h1);
                rd(5'h00, rv);
                check("R3 flags cleared", rv, 32'h1);
                ch_term = '0; ch_halt = '0; ch_aerr = '0;
            end
        end

        // R5 write 1 keeps bits, software cannot set
        @(negedge clk);
        ch_term = 6'b100001;
        @(negedge clk);
        ch_term = '0;
        wr(5'h04, 32'h0000_003E);
        rd(5'h04, rv);
        check("R5 keep on write 1", rv, 32'h20);
        wr(5'h04, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, rv);
        check("R5 software cannot set", rv, 32'h0);

        // R5 event wins over simultaneous clear
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h0; ch_term[2] = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; ch_term = '0;
        rd(5'h04, rv);
        check("R5 event beats clear", rv, 32'h4);

        // R6 global enable gates irq
        wr(5'h00, 32'h0);
        check("R6 irq masked by enable", {31'h0, irq}, 32'h0);
        wr(5'h00, 32'h1);
        check("R6 irq with enable", {31'h0, irq}, 32'h1);
        wr(5'h04, 32'h0);

        // R3 halt event beats simultaneous clear; write 1 keeps
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h1; ch_halt[0] = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; ch_halt = '0;
        rd(5'h00, rv);
        check("R3 set beats clear", rv, 32'h9);
        wr(5'h00, 32'h9);
        rd(5'h00, rv);
        check("R3 write 1 keeps", rv, 32'h9);
        wr(5'h00, 32'h1);
        wr(5'h04, 32'h0);

        // R10 R11 programmable mask
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h1C, rv);
        check("R10 R11 prog mask", rv, 32'h3F);
        wr(5'h1C, 32'h15);
        rd(5'h1C, rv);
        check("R10 prog mask value", rv, 32'h15);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule